// File: doc/BRIEF.md
# Round-Robin Event Builder Selector

This block picks the event builder that receives each accepted event, out of up to sixteen. A 32-bit configuration word says which builders are enabled and how many events in a row one builder receives. The selection then moves to the next enabled builder in ascending order and wraps from the highest back to the lowest. Grouping several events on one builder produces fewer, larger data packets downstream.

Calibration events can take a fixed path to one dedicated builder instead of the rotation. Such events leave the rotation position and the burst counter unchanged, so ordinary traffic resumes exactly where it stopped. The builder number is registered and comes out one cycle after the event strobe, together with a valid flag.

Top module: `eb_rr_selector`

## Requirements
- R1: After reset, no valid result is output, and the configuration is enabled mask 0x0001, burst length 0 and calibration bypass off, so every event is sent to builder 0.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `evt_valid` is high, and low otherwise.
- R3: Non-bypassed events go to the enabled builders (mask field, configuration bits 15:0, bit i enables builder i) in ascending order, wrapping from the highest enabled builder to the lowest.
- R4: The burst field (configuration bits 23:16) sets how many consecutive non-bypassed events one builder receives before the selection advances; a value of 0 behaves like 1.
- R5: When bypass (configuration bit 28) is set, an event with `evt_calib` high goes to the builder given by configuration bits 27:24.
- R6: A bypassed calibration event changes neither the rotation position nor the burst count.
- R7: When bit 28 is clear, calibration events take part in the rotation and the burst count like any other event.
- R8: A pulse on `cfg_wr` loads `cfg_in`, restarts the rotation at the lowest enabled builder and clears the burst count. An event in the same cycle is served with the previous configuration and state.
- R9: With an all-zero mask, every non-bypassed event goes to builder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | One accepted event in this cycle |
| evt_calib | input | 1 | The event is a calibration trigger |
| cfg_wr | input | 1 | Load `cfg_in` into the configuration |
| cfg_in | input | 32 | Configuration word: mask 15:0, burst 23:16, calibration builder 27:24, bypass 28 |
| out_valid | output | 1 | The builder number is valid |
| out_id | output | 4 | Builder chosen for the event of the previous cycle |

## Verification
Every builder number and valid flag is due one clock after the cycle in which the event is driven. A configuration write takes effect from the next cycle's event onward. The bench drives its inputs on the falling edge. On the next falling edge it compares the outputs with the expectation it computed when it drove the previous cycle, so each result is checked at exactly one edge of latency. Back-to-back events, events in the same cycle as a write, and randomly mixed traffic all go through this same one-cycle pipeline in the reference model.

// File: rtl/eb_sel_pkg.sv
package eb_sel_pkg;
    localparam int NB_BUILDERS = 16;
    localparam int ID_W        = $clog2(NB_BUILDERS);
    localparam int BURST_W     = 8;

    typedef struct packed {
        logic [2:0]             spare;
        logic                   calib_bypass;
        logic [ID_W-1:0]        calib_id;
        logic [BURST_W-1:0]     burst;
        logic [NB_BUILDERS-1:0] mask;
    } eb_cfg_t;

    localparam eb_cfg_t CFG_RESET = '{spare: 3'd0, calib_bypass: 1'b0,
                                      calib_id: '0, burst: '0,
                                      mask: {{(NB_BUILDERS-1){1'b0}}, 1'b1}};

    function automatic logic [ID_W-1:0] lowest_set(input logic [NB_BUILDERS-1:0] v);
        logic [ID_W-1:0] r;
        r = '0;
        for (int i = NB_BUILDERS-1; i >= 0; i--) begin
            if (v[i]) r = ID_W'(i);
        end
        return r;
    endfunction

    function automatic logic [BURST_W:0] burst_limit(input logic [BURST_W-1:0] b);
        return (b == '0) ? (BURST_W+1)'(1) : {1'b0, b};
    endfunction
endpackage

// File: rtl/eb_pick.sv
module eb_pick
    import eb_sel_pkg::*;
(
    input  logic [NB_BUILDERS-1:0] cand,
    input  logic [NB_BUILDERS-1:0] full_mask,
    output logic [ID_W-1:0]        sel,
    output logic [NB_BUILDERS-1:0] rest
);
    logic [NB_BUILDERS-1:0] above;

    always_comb begin
        sel   = lowest_set(cand);
        above = cand;
        for (int i = 0; i < NB_BUILDERS; i++) begin
            if (ID_W'(i) <= sel) above[i] = 1'b0;
        end
        rest = (above == '0) ? full_mask : above;
    end
endmodule

// File: rtl/eb_burst_cnt.sv
module eb_burst_cnt
    import eb_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               inc,
    input  logic [BURST_W-1:0] burst,
    output logic               wrap,
    output logic [BURST_W-1:0] cnt
);
    logic [BURST_W:0] next_cnt;

    always_comb begin
        next_cnt = {1'b0, cnt} + 1'b1;
        wrap     = inc && (next_cnt >= burst_limit(burst));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= wrap ? '0 : next_cnt[BURST_W-1:0];
        end
    end
endmodule

// File: rtl/eb_rr_selector.sv
module eb_rr_selector
    import eb_sel_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            evt_valid,
    input  logic            evt_calib,
    input  logic            cfg_wr,
    input  logic [31:0]     cfg_in,
    output logic            out_valid,
    output logic [ID_W-1:0] out_id
);
    eb_cfg_t                cfg_q;
    eb_cfg_t                cfg_new;
    logic [ID_W-1:0]        cur_sel;
    logic [NB_BUILDERS-1:0] work_mask;
    logic [ID_W-1:0]        init_sel, adv_sel;
    logic [NB_BUILDERS-1:0] init_rest, adv_rest;
    logic                   bypass, count_evt, wrap;
    logic [BURST_W-1:0]     burst_cnt;

    assign cfg_new   = eb_cfg_t'(cfg_in);
    assign bypass    = evt_calib && cfg_q.calib_bypass;
    assign count_evt = evt_valid && !bypass;

    eb_pick u_pick_init (
        .cand      (cfg_new.mask),
        .full_mask (cfg_new.mask),
        .sel       (init_sel),
        .rest      (init_rest)
    );

    eb_pick u_pick_adv (
        .cand      (work_mask),
        .full_mask (cfg_q.mask),
        .sel       (adv_sel),
        .rest      (adv_rest)
    );

    eb_burst_cnt u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (cfg_wr),
        .inc   (count_evt),
        .burst (cfg_q.burst),
        .wrap  (wrap),
        .cnt   (burst_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= CFG_RESET;
            cur_sel   <= '0;
            work_mask <= CFG_RESET.mask;
        end else if (cfg_wr) begin
            cfg_q     <= cfg_new;
            cur_sel   <= init_sel;
            work_mask <= init_rest;
        end else if (wrap) begin
            cur_sel   <= adv_sel;
            work_mask <= adv_rest;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_id    <= '0;
        end else begin
            out_valid <= evt_valid;
            if (evt_valid) out_id <= bypass ? cfg_q.calib_id : cur_sel;
        end
    end
endmodule

// File: rtl/eb_rr_selector_chk.sv
module eb_rr_selector_chk (
    input logic        clk,
    input logic        rst,
    input logic        evt_valid,
    input logic        evt_calib,
    input logic        cfg_wr,
    input logic        out_valid,
    input logic [3:0]  out_id,
    input logic [31:0] cfg_q,
    input logic [3:0]  cur_sel,
    input logic [7:0]  burst_cnt
);
    logic [15:0] mask_q;
    logic [8:0]  lim;
    assign mask_q = cfg_q[15:0];
    assign lim    = (cfg_q[23:16] == 8'd0) ? 9'd1 : {1'b0, cfg_q[23:16]};

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        evt_valid |=> out_valid);
    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !evt_valid |=> !out_valid);
    assert_bypass_id_R5: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_calib && cfg_q[28]) |=> (out_id == $past(cfg_q[27:24])));
    assert_bypass_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_calib && cfg_q[28] && !cfg_wr) |=> ($stable(cur_sel) && $stable(burst_cnt)));
    assert_sel_enabled_R3: assert property (@(posedge clk) disable iff (rst)
        (mask_q != 16'd0) |-> mask_q[cur_sel]);
    assert_zero_mask_R9: assert property (@(posedge clk) disable iff (rst)
        (mask_q == 16'd0) |-> (cur_sel == 4'd0));
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, burst_cnt} < lim));
    assert_write_restart_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (burst_cnt == 8'd0));
endmodule

bind eb_rr_selector eb_rr_selector_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_valid (evt_valid),
    .evt_calib (evt_calib),
    .cfg_wr    (cfg_wr),
    .out_valid (out_valid),
    .out_id    (out_id),
    .cfg_q     (cfg_q),
    .cur_sel   (cur_sel),
    .burst_cnt (burst_cnt)
);

// File: tb/eb_rr_selector_bench.sv
module eb_rr_selector_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 1'b0;
    logic        evt_calib = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_in = '0;
    logic        out_valid;
    logic [3:0]  out_id;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    logic [15:0] m_mask;
    logic [7:0]  m_burst;
    logic [3:0]  m_cid;
    logic        m_byp;
    logic [3:0]  m_cur;
    int          m_cnt;
    logic        exp_valid;
    logic [3:0]  exp_id;
    string       exp_tag;

    always #2.5 clk = ~clk;

    eb_rr_selector u_eb_rr_selector (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_calib(evt_calib),
        .cfg_wr(cfg_wr), .cfg_in(cfg_in), .out_valid(out_valid), .out_id(out_id)
    );

    function automatic logic [3:0] first_en(input logic [15:0] m);
        for (int i = 0; i < 16; i++) if (m[i]) return 4'(i);
        return 4'd0;
    endfunction

    function automatic logic [3:0] next_en(input logic [15:0] m, input logic [3:0] c);
        for (int i = 0; i < 16; i++) if (i > int'(c) && m[i]) return 4'(i);
        return first_en(m);
    endfunction

    function automatic logic [31:0] mk_cfg(input logic [15:0] m, input logic [7:0] b,
                                           input logic [3:0] cid, input logic byp);
        return {3'b000, byp, cid, b, m};
    endfunction

    task automatic check_prev();
        n_cmp++;
        if (out_valid !== exp_valid || (exp_valid && out_id !== exp_id)) begin
            n_bad++;
            $display("FAIL %s: valid/id actual %0b/%0d expected %0b/%0d",
                     exp_tag, out_valid, out_id, exp_valid, exp_id);
        end
    endtask

    // one cycle: check the previous cycle's result, then drive this cycle
    task automatic step(input logic ev, input logic cal, input logic wr,
                        input logic [31:0] cfg, input string tag);
        int lim;
        @(negedge clk);
        check_prev();
        evt_valid = ev; evt_calib = cal; cfg_wr = wr; cfg_in = cfg;
        exp_valid = ev;
        exp_tag   = tag;
        if (ev) begin
            if (cal && m_byp) begin
                exp_id = m_cid;
            end else begin
                exp_id = m_cur;
                lim = (m_burst == 0) ? 1 : int'(m_burst);
                m_cnt++;
                if (m_cnt >= lim) begin
                    m_cnt = 0;
                    m_cur = next_en(m_mask, m_cur);
                end
            end
        end
        if (wr) begin
            m_mask = cfg[15:0]; m_burst = cfg[23:16];
            m_cid = cfg[27:24]; m_byp = cfg[28];
            m_cur = first_en(m_mask); m_cnt = 0;
        end
    endtask

    task automatic write_cfg(input logic [31:0] c, input string tag);
        step(1'b0, 1'b0, 1'b1, c, tag);
    endtask

    task automatic ev(input logic cal, input string tag);
        step(1'b1, cal, 1'b0, 32'd0, tag);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        m_mask = 16'h0001; m_burst = 0; m_cid = 0; m_byp = 0; m_cur = 0; m_cnt = 0;
        exp_valid = 0; exp_id = 0; exp_tag = "R1";
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: idle after reset, then default config sends to builder 0
        step(1'b0, 1'b0, 1'b0, 32'd0, "R1");
        for (int i = 0; i < 3; i++) ev(1'b0, "R1");
        ev(1'b1, "R1");
        // R3 + R4 zero burst acts as one: 0,5,10,15,0
        write_cfg(mk_cfg(16'h8421, 8'd0, 4'd0, 1'b0), "R8");
        for (int i = 0; i < 6; i++) ev(1'b0, "R3");
        // R4 burst of 3 over builders 1,2
        write_cfg(mk_cfg(16'h0006, 8'd3, 4'd0, 1'b0), "R8");
        for (int i = 0; i < 8; i++) ev(1'b0, "R4");
        // R5/R6 bypass interleaved with burst 2 on 4,5
        write_cfg(mk_cfg(16'h0030, 8'd2, 4'd9, 1'b1), "R8");
        ev(1'b0, "R6"); ev(1'b1, "R5"); ev(1'b0, "R6"); ev(1'b1, "R5");
        ev(1'b1, "R5"); ev(1'b0, "R6"); ev(1'b0, "R6");
        // R7 calib participates when bypass off
        write_cfg(mk_cfg(16'h0300, 8'd1, 4'd9, 1'b0), "R8");
        ev(1'b1, "R7"); ev(1'b1, "R7"); ev(1'b1, "R7");
        // R9 zero mask
        write_cfg(mk_cfg(16'h0000, 8'd2, 4'd3, 1'b0), "R8");
        for (int i = 0; i < 4; i++) ev(1'b0, "R9");
        // R8 write mid-burst with an event in the same cycle
        write_cfg(mk_cfg(16'h00c0, 8'd4, 4'd0, 1'b0), "R8");
        ev(1'b0, "R8"); ev(1'b0, "R8");
        step(1'b1, 1'b0, 1'b1, mk_cfg(16'h0a00, 8'd2, 4'd1, 1'b0), "R8");
        for (int i = 0; i < 4; i++) ev(1'b0, "R8");
        // random mix
        for (int i = 0; i < 2000; i++) begin
            logic e, c, w;
            logic [31:0] r;
            e = ($urandom % 4) != 0;
            c = ($urandom % 4) == 0;
            w = ($urandom % 40) == 0;
            r = mk_cfg(16'($urandom), 8'($urandom % 5), 4'($urandom), 1'($urandom));
            if (($urandom % 8) == 0) r[15:0] = 16'h0;
            step(e, c, w, r, "R3");
        end
        step(1'b0, 1'b0, 1'b0, 32'd0, "R2");
        @(negedge clk);
        check_prev();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule